// File: doc/BRIEF.md
# DMA descriptor chaining engine

A controller for one DMA channel. Software loads a transfer descriptor of four words through a small register-write port. The descriptor carries a start address, a beat count, an address modifier and a control word. Once all four words are present, the channel runs the block. It issues one data-move request per beat, and the address steps by the modifier on each acknowledged beat.

When a block's count reaches zero, the control word decides what happens next. If the chain-enable flag is set and the chain pointer is non-zero, the channel reads the next descriptor from memory at that pointer and runs it. Otherwise the channel returns to idle. Each descriptor can ask for an interrupt at the end of its own block. Setting that flag only in the last descriptor of a chain gives a single interrupt per sequence.

A pause input freezes an active block. The chain pointer of the running descriptor can be replaced while the block runs, which redirects the chain.

Top module: `dma_chain_eng`

## Requirements
- R1: After reset the status is idle (code 0), and no data request, no memory request and no interrupt is asserted.
- R2: Descriptor words are written by register index. Index 0 is the address in bits [15:0]. Index 1 holds the count in bits [15:0] and the modifier in bits [31:16]. Index 2 holds chain-enable in bit 0, interrupt-enable in bit 1 and the chain pointer in bits [31:16]. Index 3 is reserved. Once all four indices have been written while idle, in any order, the block starts on the next cycle with status code 2.
- R3: A data request is raised only while the remaining count is non-zero. Each acknowledged beat adds the modifier to the address (modulo 2^16) and lowers the count by one. A block whose count is zero ends without any beat.
- R4: When a block ends and its interrupt-enable bit is 1, `irq_o` is high for exactly the following cycle. No pulse is produced when the bit is 0.
- R5: When a block ends with chain-enable 1 and a non-zero chain pointer, status becomes 1. The channel then requests memory words at pointer, pointer+1, pointer+2 and pointer+3 on four consecutive cycles. Each word is read one cycle after its request. The next block then starts from the fetched address, count/modifier and control words.
- R6: When a block ends with chain-enable 0, or with a chain pointer of zero, the channel becomes idle and makes no memory request.
- R7: While a block runs, a write to index 2 replaces only the chain pointer, and the two flag bits keep their value. Writes to indices 0, 1 and 3 are ignored and do not count toward the next descriptor load.
- R8: While `pause_i` is high during a block, status is 3, no data request is made, and the address and count hold. When pause drops, the block resumes from the held state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| reg_we_i | input | 1 | descriptor word write strobe |
| reg_idx_i | input | 2 | descriptor word index |
| reg_wdata_i | input | 32 | descriptor word data |
| pause_i | input | 1 | hold the active block |
| mem_req_o | output | 1 | descriptor fetch read request |
| mem_addr_o | output | 16 | descriptor fetch word address |
| mem_rdata_i | input | 32 | read data, valid one cycle after the request |
| xfer_req_o | output | 1 | data-move request for one beat |
| xfer_addr_o | output | 16 | address of the current beat |
| xfer_ack_i | input | 1 | beat accepted |
| irq_o | output | 1 | block-end interrupt pulse |
| status_o | output | 2 | 0 idle, 1 fetching, 2 transferring, 3 paused |

## Verification
The first runs use single blocks without chaining. One has a positive modifier and every beat acknowledged. Another loads its words in a scrambled order and uses a negative modifier. Together they separate a correct load trigger and address stepping from designs that only start on the last index or mishandle wrap. A three-link chain follows, with an irregular acknowledge and a zero-count middle link. It also places the interrupt only on the last link, which tells per-block interrupts apart from chain-end ones and checks the fetch order. Further runs set chain-enable with a null pointer, pause in the middle of a block, and rewrite the pointer during a block while also writing stray words. These show that the flags survive the rewrite and that stray writes stay out of the next load.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned FIELD_W = 16;
  localparam int unsigned N_WORDS = 4;
  localparam int unsigned IDX_W   = $clog2(N_WORDS);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_XFER  = 2'd2,
    ST_HOLD  = 2'd3
  } ch_status_e;

  typedef struct packed {
    logic [FIELD_W-1:0] addr;
    logic [FIELD_W-1:0] cnt;
    logic [FIELD_W-1:0] mod;
    logic               chain_en;
    logic               int_en;
    logic [FIELD_W-1:0] ptr;
  } desc_t;

  function automatic desc_t unpack_desc(logic [WORD_W-1:0] w0,
                                        logic [WORD_W-1:0] w1,
                                        logic [WORD_W-1:0] w2);
    desc_t d;
    d.addr     = w0[FIELD_W-1:0];
    d.cnt      = w1[FIELD_W-1:0];
    d.mod      = w1[WORD_W-1:WORD_W-FIELD_W];
    d.chain_en = w2[0];
    d.int_en   = w2[1];
    d.ptr      = w2[WORD_W-1:WORD_W-FIELD_W];
    return d;
  endfunction
endpackage

// File: rtl/dce_stage.sv
module dce_stage
  import dma_chain_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              accept_i,
  input  logic              take_i,
  output logic              full_o,
  output logic [WORD_W-1:0] w0_o,
  output logic [WORD_W-1:0] w1_o,
  output logic [WORD_W-1:0] w2_o
);
  logic [N_WORDS-1:0] seen_q;
  logic [WORD_W-1:0]  word_q [N_WORDS-1];

  for (genvar i = 0; i < N_WORDS - 1; i++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                          word_q[i] <= '0;
      else if (we_i && accept_i && !take_i && idx_i == i)   word_q[i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       seen_q <= '0;
    else if (take_i)                   seen_q <= '0;
    else if (we_i && accept_i)         seen_q <= seen_q | (N_WORDS'(1) << idx_i);
  end

  assign full_o = &seen_q;
  assign w0_o   = word_q[0];
  assign w1_o   = word_q[1];
  assign w2_o   = word_q[2];
endmodule

// File: rtl/dce_fetch.sv
module dce_fetch
  import dma_chain_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [FIELD_W-1:0] ptr_i,
  output logic               mem_req_o,
  output logic [FIELD_W-1:0] mem_addr_o,
  input  logic [WORD_W-1:0]  mem_rdata_i,
  output logic               done_o,
  output desc_t              desc_o
);
  localparam int unsigned K_W = $clog2(N_WORDS) + 1;

  logic               busy_q;
  logic [K_W-1:0]     k_q;
  logic [FIELD_W-1:0] base_q;
  logic [WORD_W-1:0]  fw_q [N_WORDS-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      k_q    <= '0;
      base_q <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      k_q    <= '0;
      base_q <= ptr_i;
    end else if (busy_q) begin
      if (k_q == K_W'(N_WORDS)) busy_q <= 1'b0;
      else                      k_q    <= k_q + 1'b1;
    end
  end

  // word k-1 arrives while request k is out; the reserved word is dropped
  for (genvar i = 0; i < N_WORDS - 1; i++) begin : g_cap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 fw_q[i] <= '0;
      else if (busy_q && k_q == K_W'(i + 1))       fw_q[i] <= mem_rdata_i;
    end
  end

  assign mem_req_o  = busy_q && (k_q < K_W'(N_WORDS));
  assign mem_addr_o = base_q + FIELD_W'(k_q);
  assign done_o     = busy_q && (k_q == K_W'(N_WORDS));
  assign desc_o     = unpack_desc(fw_q[0], fw_q[1], fw_q[2]);
endmodule

// File: rtl/dma_chain_eng.sv
module dma_chain_eng
  import dma_chain_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [IDX_W-1:0]   reg_idx_i,
  input  logic [WORD_W-1:0]  reg_wdata_i,
  input  logic               pause_i,
  output logic               mem_req_o,
  output logic [FIELD_W-1:0] mem_addr_o,
  input  logic [WORD_W-1:0]  mem_rdata_i,
  output logic               xfer_req_o,
  output logic [FIELD_W-1:0] xfer_addr_o,
  input  logic               xfer_ack_i,
  output logic               irq_o,
  output logic [1:0]         status_o
);
  ch_status_e         state_q;
  logic [FIELD_W-1:0] addr_q, cnt_q, mod_q, ptr_q;
  logic               ce_q, ie_q, irq_q;

  logic               st_full, take, fetch_start, fetch_done, blk_end;
  logic [WORD_W-1:0]  sw0, sw1, sw2;
  desc_t              st_desc, f_desc;

  assign take = (state_q == ST_IDLE) && st_full;

  dce_stage u_stage (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .idx_i(reg_idx_i), .wdata_i(reg_wdata_i),
    .accept_i(state_q == ST_IDLE), .take_i(take),
    .full_o(st_full), .w0_o(sw0), .w1_o(sw1), .w2_o(sw2)
  );

  assign st_desc     = unpack_desc(sw0, sw1, sw2);
  assign blk_end     = (state_q == ST_XFER) && !pause_i && (cnt_q == '0);
  assign fetch_start = blk_end && ce_q && (ptr_q != '0);

  dce_fetch u_fetch (
    .clk_i, .rst_ni,
    .start_i(fetch_start), .ptr_i(ptr_q),
    .mem_req_o, .mem_addr_o, .mem_rdata_i,
    .done_o(fetch_done), .desc_o(f_desc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      cnt_q   <= '0;
      mod_q   <= '0;
      ptr_q   <= '0;
      ce_q    <= 1'b0;
      ie_q    <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (st_full) begin
          {addr_q, cnt_q, mod_q, ce_q, ie_q, ptr_q} <= st_desc;
          state_q <= ST_XFER;
        end
        ST_FETCH: if (fetch_done) begin
          {addr_q, cnt_q, mod_q, ce_q, ie_q, ptr_q} <= f_desc;
          state_q <= ST_XFER;
        end
        ST_XFER: begin
          if (blk_end) begin
            irq_q   <= ie_q;
            state_q <= fetch_start ? ST_FETCH : ST_IDLE;
          end else if (!pause_i && xfer_ack_i) begin
            addr_q <= addr_q + mod_q;
            cnt_q  <= cnt_q - 1'b1;
          end
          if (reg_we_i && reg_idx_i == IDX_W'(2))
            ptr_q <= reg_wdata_i[WORD_W-1:WORD_W-FIELD_W];
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign xfer_req_o  = (state_q == ST_XFER) && !pause_i && (cnt_q != '0);
  assign xfer_addr_o = addr_q;
  assign irq_o       = irq_q;
  assign status_o    = ((state_q == ST_XFER) && pause_i) ? ST_HOLD : state_q;
endmodule

// File: rtl/dce_chk.sv
module dce_chk
  import dma_chain_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               xfer_req_o,
  input logic               xfer_ack_i,
  input logic [FIELD_W-1:0] xfer_addr_o,
  input logic [FIELD_W-1:0] cnt_q,
  input logic [FIELD_W-1:0] mod_q,
  input logic               mem_req_o,
  input logic [FIELD_W-1:0] mem_addr_o,
  input logic               irq_o,
  input logic [1:0]         status_o
);
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o == 2'd0 |-> !xfer_req_o && !mem_req_o);

  a_r3_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_req_o && xfer_ack_i |=> xfer_addr_o == $past(FIELD_W'(xfer_addr_o + mod_q)));

  a_r3_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_req_o && xfer_ack_i |=> cnt_q == $past(FIELD_W'(cnt_q - 1'b1)));

  a_r4_irq_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  a_r5_fetch_seq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && $past(mem_req_o) |-> mem_addr_o == $past(FIELD_W'(mem_addr_o + 1'b1)));

  a_r6_fetch_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> status_o == 2'd1);

  a_r8_pause_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o == 2'd3 |-> !xfer_req_o);

  a_r8_pause_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o == 2'd3 && $past(status_o) == 2'd3 |-> $stable(xfer_addr_o) && $stable(cnt_q));
endmodule

bind dma_chain_eng dce_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .xfer_req_o(xfer_req_o), .xfer_ack_i(xfer_ack_i), .xfer_addr_o(xfer_addr_o),
  .cnt_q(cnt_q), .mod_q(mod_q),
  .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
  .irq_o(irq_o), .status_o(status_o)
);

// File: tb/sim_dma_chain_eng.sv
`timescale 1ns/1ps
module sim_dma_chain_eng;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic        pause = 1'b0;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic [31:0] mem_rdata = '0;
  logic        xfer_req;
  logic [15:0] xfer_addr;
  logic        ack = 1'b0;
  logic        irq;
  logic [1:0]  status;

  int total = 0, bad = 0, cyc = 0;
  int ack_mode = 0;
  int beats = 0, irqs = 0, mreqs = 0, first_maddr = -1;
  logic [31:0] mem [64];

  always #4 clk = ~clk;

  dma_chain_eng u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_idx_i(reg_idx), .reg_wdata_i(reg_wdata),
    .pause_i(pause),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .xfer_req_o(xfer_req), .xfer_addr_o(xfer_addr), .xfer_ack_i(ack),
    .irq_o(irq), .status_o(status)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: act=%0h exp=%0h (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  // memory: registered read, one cycle latency
  always @(posedge clk) if (mem_req) mem_rdata <= mem[mem_addr[5:0]];

  // ---------------- behavioural reference model ----------------
  int m_st, m_addr, m_cnt, m_mod, m_ce, m_ie, m_ptr, m_irq, m_k, m_fptr, m_mask;
  int sw [4];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_addr = 0; m_cnt = 0; m_mod = 0; m_ce = 0; m_ie = 0;
      m_ptr = 0; m_irq = 0; m_k = 0; m_fptr = 0; m_mask = 0;
      for (int i = 0; i < 4; i++) sw[i] = 0;
    end else begin
      int nptr;
      m_irq = 0;
      nptr = m_ptr;
      if (m_st == 0) begin
        if (m_mask == 15) begin
          m_addr = sw[0] & 16'hffff; m_cnt = sw[1] & 16'hffff; m_mod = (sw[1] >>> 16) & 16'hffff;
          m_ce = sw[2] & 1; m_ie = (sw[2] >>> 1) & 1; m_ptr = (sw[2] >>> 16) & 16'hffff;
          m_mask = 0; m_st = 2;
        end else if (reg_we) begin
          sw[reg_idx] = reg_wdata; m_mask = m_mask | (1 << reg_idx);
        end
      end else if (m_st == 1) begin
        if (m_k == 4) begin
          int a0, a1, a2;
          a0 = mem[(m_fptr) & 63]; a1 = mem[(m_fptr + 1) & 63]; a2 = mem[(m_fptr + 2) & 63];
          m_addr = a0 & 16'hffff; m_cnt = a1 & 16'hffff; m_mod = (a1 >>> 16) & 16'hffff;
          m_ce = a2 & 1; m_ie = (a2 >>> 1) & 1; m_ptr = (a2 >>> 16) & 16'hffff;
          m_st = 2;
        end else m_k++;
      end else begin
        if (reg_we && reg_idx == 2) nptr = (reg_wdata >>> 16) & 16'hffff;
        if (!pause) begin
          if (m_cnt == 0) begin
            m_irq = m_ie;
            if (m_ce != 0 && m_ptr != 0) begin m_st = 1; m_k = 0; m_fptr = m_ptr; end
            else m_st = 0;
          end else if (ack) begin
            m_addr = (m_addr + m_mod) & 16'hffff; m_cnt = m_cnt - 1;
          end
        end
        m_ptr = nptr;
      end
    end
  end

  // per-cycle comparison, away from both clock edges
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      int e_st, e_xreq, e_mreq;
      e_xreq = (m_st == 2 && !pause && m_cnt != 0);
      e_mreq = (m_st == 1 && m_k < 4);
      e_st   = (m_st == 2 && pause) ? 3 : m_st;
      chk(status == 2'(e_st), "R8", "status", status, e_st);
      chk(xfer_req == 1'(e_xreq), "R3", "xfer_req", xfer_req, e_xreq);
      if (e_xreq) chk(xfer_addr == 16'(m_addr), "R3", "xfer_addr", xfer_addr, m_addr);
      chk(mem_req == 1'(e_mreq), "R5", "mem_req", mem_req, e_mreq);
      if (e_mreq) chk(mem_addr == 16'(m_fptr + m_k), "R5", "mem_addr", mem_addr, m_fptr + m_k);
      chk(irq == 1'(m_irq), "R4", "irq", irq, m_irq);
    end
  end

  // activity counters from the ports
  always @(posedge clk) begin
    cyc++;
    if (rst_n) begin
      if (xfer_req && ack) beats++;
      if (irq) irqs++;
      if (mem_req) begin
        if (mreqs == 0) first_maddr = int'(mem_addr);
        mreqs++;
      end
    end
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL R2 watchdog: act=hung exp=idle");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // acknowledge pattern, changed at the falling edge
  always @(negedge clk) ack <= (ack_mode == 0) ? 1'b1 : ((cyc % 3) != 1);

  function automatic logic [31:0] w1(int cnt, int mod);
    return {16'(mod), 16'(cnt)};
  endfunction
  function automatic logic [31:0] w2(int ce, int ie, int ptr);
    return {16'(ptr), 14'd0, 1'(ie), 1'(ce)};
  endfunction

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_idx = 2'(idx); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic load(input int a, input int cnt, input int mod,
                      input int ce, input int ie, input int ptr);
    wr(0, 32'(a)); wr(1, w1(cnt, mod)); wr(2, w2(ce, ie, ptr)); wr(3, 32'h0);
  endtask

  task automatic clr();
    beats = 0; irqs = 0; mreqs = 0; first_maddr = -1;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    for (int i = 0; i < 2000 && status != 2'd0; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    // chain: 0x10 -> 0x20 (zero count) -> 0x30 (last, interrupt)
    mem[16] = 32'h0000_fffe; mem[17] = w1(3, 1); mem[18] = w2(1, 0, 16'h20);
    mem[32] = 32'h0000_0400; mem[33] = w1(0, 5); mem[34] = w2(1, 0, 16'h30);
    mem[48] = 32'h0000_0500; mem[49] = w1(1, 7); mem[50] = w2(0, 1, 0);

    repeat (3) @(negedge clk);
    chk(status == 2'd0 && !xfer_req && !mem_req && !irq, "R1", "reset outputs",
        {status, xfer_req, mem_req, irq}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(status == 2'd0 && !xfer_req, "R1", "idle after reset", status, 0);

    // single block, positive modifier, interrupt
    clr(); ack_mode = 0;
    load(16'h100, 3, 2, 0, 1, 0);
    @(negedge clk); #2;
    chk(status == 2'd2, "R2", "start after full load", status, 2);
    wait_idle();
    chk(beats == 3, "R3", "beats single", beats, 3);
    chk(irqs == 1, "R4", "irq single", irqs, 1);
    chk(mreqs == 0, "R6", "no fetch without chain", mreqs, 0);

    // scrambled word order, negative modifier, no interrupt
    clr(); ack_mode = 1;
    wr(3, 32'h0); wr(1, w1(2, 16'hffff)); wr(2, w2(0, 0, 16'h10)); wr(0, 32'h200);
    wait_idle();
    chk(beats == 2, "R2", "beats scrambled", beats, 2);
    chk(irqs == 0, "R4", "no irq when disabled", irqs, 0);

    // three-link chain, interrupt only on last
    clr(); ack_mode = 1;
    load(16'h300, 2, 1, 1, 0, 16'h10);
    wait_idle();
    chk(beats == 6, "R5", "beats chain", beats, 6);
    chk(mreqs == 12, "R5", "fetch reads", mreqs, 12);
    chk(first_maddr == 16, "R5", "first fetch addr", first_maddr, 16);
    chk(irqs == 1, "R4", "one irq per chain", irqs, 1);

    // chain enabled with null pointer
    clr(); ack_mode = 0;
    load(16'h600, 1, 1, 1, 1, 0);
    wait_idle();
    chk(mreqs == 0, "R6", "null pointer ends chain", mreqs, 0);
    chk(irqs == 1, "R6", "irq at null end", irqs, 1);

    // pause mid-block
    clr(); ack_mode = 0;
    load(16'h700, 4, 4, 0, 1, 0);
    @(negedge clk);
    pause = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    chk(status == 2'd3, "R8", "paused status", status, 3);
    chk(!xfer_req, "R8", "no req while paused", xfer_req, 0);
    repeat (3) @(negedge clk);
    pause = 1'b0;
    wait_idle();
    chk(beats == 4, "R8", "beats after resume", beats, 4);

    // pointer rewrite during a block, stray writes
    clr(); ack_mode = 0;
    load(16'h800, 6, 1, 1, 0, 16'h10);
    @(negedge clk);
    wr(2, w2(0, 0, 16'h30));
    wr(0, 32'h0000_0bad);
    wait_idle();
    chk(first_maddr == 48, "R7", "redirected fetch", first_maddr, 48);
    chk(mreqs == 4, "R7", "flags kept, one fetch", mreqs, 4);
    chk(beats == 7, "R7", "beats redirect", beats, 7);
    chk(irqs == 1, "R7", "irq redirect", irqs, 1);

    // stray index-0 write must not count toward the next load
    clr();
    wr(1, w1(1, 1)); wr(2, w2(0, 0, 0)); wr(3, 32'h0);
    repeat (4) @(negedge clk); #2;
    chk(status == 2'd0, "R7", "no start with word 0 missing", status, 0);
    wr(0, 32'h900);
    @(negedge clk); #2;
    chk(status == 2'd2, "R2", "start after last word", status, 2);
    wait_idle();
    chk(beats == 1, "R2", "beats last load", beats, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule